// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is a single 16-bit timer channel controlled through a small register port. A counter advances on ticks from a prescaler, or from one of two external clock inputs. The control byte selects the tick source and the edge that counts. Each of the two general registers works in one of two ways. In compare mode it drives an output pin that is cleared, set or toggled when the counter reaches the register's value. In capture mode it latches the counter when an edge arrives on its capture pin.

Either general register can restart the counter, so the channel makes a periodic event with a programmable period. Match, capture and overflow events set sticky status flags. Software clears a flag by reading it as 1 and then writing 0 to it. A masked OR of the flags drives a level interrupt. The channel counts only while its run input is high. That input comes from a start register outside the block, which several channels share.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0 and both general registers read 0xFFFF. The control, I/O-control, interrupt-enable and status registers read 0. Both compare pins and `irq` are low.
- R2: The counter changes only while `run` is high, apart from bus writes. When `run` is low the counter holds its value.
- R3: Control bits 2:0 pick the tick source. Codes 0, 1, 2, 3, 4 and 5 give one rising-edge tick every 1, 4, 16, 64, 256 and 1024 clock cycles. Code 0 ticks on every cycle whatever the edge field holds.
- R4: Control bits 4:3 pick the counting edge: 0 is rising, 1 is falling, and 2 or 3 is both. With both edges, a divided clock ticks twice as often.
- R5: Tick codes 6 and 7 count edges on `ext_clk_a` and `ext_clk_b` respectively, after synchronisation. Edges on the input that is not selected are ignored.
- R6: Control bits 7:5 pick the clear source. Code 1 clears on a compare match with register A and code 2 clears on a match with register B. Any other code lets the counter run freely. When clearing is on, the counter goes to 0 on the tick after it reaches the register's value, so one period is the register value plus one ticks.
- R7: In compare mode, a match sets the flag for its register (status bit 0 for A, bit 1 for B) on the same clock edge at which the counter takes the register's value.
- R8: Each 4-bit I/O-control nibble (low nibble for A, high nibble for B) controls its pin. Writing code 1, 2 or 3 drives the pin to 0; writing code 5, 6 or 7 drives it to 1. On a match, codes 1 and 5 drive the pin low, codes 2 and 6 drive it high, and codes 3 and 7 toggle it. Code 0 leaves the pin unchanged.
- R9: I/O-control codes 8, 9 and 10 make a register capture the counter on a rising, falling or either edge of its capture pin. A capture sets the register's flag. An edge of a kind that is not selected is ignored.
- R10: When the counter increments from 0xFFFF to 0, status bit 4 is set.
- R11: A status flag is cleared only by writing 0 to that bit after a status read that saw the bit as 1. Writing 1 leaves the flag unchanged, and so does writing 0 without a prior read.
- R12: `irq` is high exactly while some status flag in bits 0, 1 or 4 is set and the interrupt-enable bit at the same position is also set.
- R13: The register addresses are 0 control, 1 I/O control, 2 interrupt enable, 3 status, 4 counter, 5 register A and 6 register B. Address 7 reads 0. A write takes effect at the next clock edge, and reads are combinational. Counter and general registers are 16-bit words; the other registers are 8 bits wide, held in the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | This channel's bit from the shared start register |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to arm flag clearing |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| ext_clk_a | input | 1 | External count clock A |
| ext_clk_b | input | 1 | External count clock B |
| cap_pin_a | input | 1 | Capture input for register A |
| cap_pin_b | input | 1 | Capture input for register B |
| cmp_out_a | output | 1 | Compare output for register A |
| cmp_out_b | output | 1 | Compare output for register B |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives inputs on falling edges. A register write is therefore visible on `bus_rdata` and on the pins at the next falling edge, one rising edge after the write strobe. Capture pins and external clocks pass through a two-stage synchroniser and an edge register, so their effect arrives on the third rising edge; the bench waits at least five cycles before it looks. Prescaler rates are checked as the spacing between successive counter changes polled each cycle, so the unknown phase of the first tick does not matter. The clear-on-match tests instead look at the exact cycle in which the counter shows the register value and the pin changes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W  = 8;
    localparam int PSC_W  = 10;
    localparam int N_GR   = 2;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_IOC  = 3'd1;
    localparam logic [2:0] ADR_IEN  = 3'd2;
    localparam logic [2:0] ADR_STAT = 3'd3;
    localparam logic [2:0] ADR_CNT  = 3'd4;
    localparam logic [2:0] ADR_GRA  = 3'd5;
    localparam logic [2:0] ADR_GRB  = 3'd6;

    localparam int FLG_A   = 0;
    localparam int FLG_B   = 1;
    localparam int FLG_OVF = 4;
    localparam logic [REG_W-1:0] FLAG_MASK = 8'h13;

    typedef struct packed {
        logic [2:0] clr_sel;
        logic [1:0] edge_sel;
        logic [2:0] clk_sel;
    } ctrl_t;

    typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_FLIP} pin_act_e;
    typedef enum logic [1:0] {CAP_OFF, CAP_RISE, CAP_FALL, CAP_BOTH} cap_edge_e;

    function automatic logic is_compare(input logic [3:0] code);
        return (code[3] == 1'b0) && (code[1:0] != 2'b00);
    endfunction

    function automatic pin_act_e pin_action(input logic [3:0] code);
        if (!is_compare(code)) return ACT_NONE;
        unique case (code[1:0])
            2'd1:    return ACT_LOW;
            2'd2:    return ACT_HIGH;
            default: return ACT_FLIP;
        endcase
    endfunction

    function automatic cap_edge_e cap_edge(input logic [3:0] code);
        unique case (code)
            4'd8:    return CAP_RISE;
            4'd9:    return CAP_FALL;
            4'd10:   return CAP_BOTH;
            default: return CAP_OFF;
        endcase
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] clk_sel,
    input  logic [1:0] edge_sel,
    input  logic       ext_a,
    input  logic       ext_b,
    output logic       tick
);

    logic [PSC_W-1:0]  psc_q;
    logic [SYNC_N-1:0] sync_a_q, sync_b_q;
    logic              src, src_q, rise, fall, edge_hit;

    always_ff @(posedge clk) begin
        if (rst || !run) psc_q <= '0;
        else             psc_q <= psc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a_q <= '0;
            sync_b_q <= '0;
            src_q    <= 1'b0;
        end else begin
            sync_a_q <= {sync_a_q[SYNC_N-2:0], ext_a};
            sync_b_q <= {sync_b_q[SYNC_N-2:0], ext_b};
            src_q    <= src;
        end
    end

    // divided clocks are psc bits; bit 2k-1 gives a period of 4^k cycles
    always_comb begin
        unique case (clk_sel)
            3'd1:    src = psc_q[1];
            3'd2:    src = psc_q[3];
            3'd3:    src = psc_q[5];
            3'd4:    src = psc_q[7];
            3'd5:    src = psc_q[9];
            3'd6:    src = sync_a_q[SYNC_N-1];
            3'd7:    src = sync_b_q[SYNC_N-1];
            default: src = 1'b0;
        endcase
    end

    assign rise = src & ~src_q;
    assign fall = ~src & src_q;

    always_comb begin
        unique case (edge_sel)
            2'd0:    edge_hit = rise;
            2'd1:    edge_hit = fall;
            default: edge_hit = rise | fall;
        endcase
    end

    assign tick = run && ((clk_sel == 3'd0) || edge_hit);

endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ioc,
    input  logic [3:0]       ioc_new,
    input  logic             ioc_wr,
    input  logic             gr_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             cap_pin,
    output logic [CNT_W-1:0] gr,
    output logic             hit,
    output logic             cap_evt,
    output logic             pin
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q, lvl, rise, fall;
    logic [CNT_W-1:0]  gr_q;
    logic              pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], cap_pin};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign lvl  = sync_q[SYNC_N-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        unique case (cap_edge(ioc))
            CAP_RISE: cap_evt = rise;
            CAP_FALL: cap_evt = fall;
            CAP_BOTH: cap_evt = rise | fall;
            default:  cap_evt = 1'b0;
        endcase
    end

    // match is judged on the value the counter is about to take
    assign hit = adv && is_compare(ioc) && (cnt_nxt == gr_q);

    always_ff @(posedge clk) begin
        if (rst)          gr_q <= '1;
        else if (gr_wr)   gr_q <= wdata;
        else if (cap_evt) gr_q <= cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (ioc_wr && is_compare(ioc_new)) begin
            pin_q <= ioc_new[2];
        end else if (hit) begin
            unique case (pin_action(ioc))
                ACT_LOW:  pin_q <= 1'b0;
                ACT_HIGH: pin_q <= 1'b1;
                ACT_FLIP: pin_q <= ~pin_q;
                default:  pin_q <= pin_q;
            endcase
        end
    end

    assign gr  = gr_q;
    assign pin = pin_q;

    AST_PIN_SET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (hit && !ioc_wr && pin_action(ioc) == ACT_HIGH) |=> pin_q); // R8
    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !gr_wr) |=> (gr_q == $past(cnt))); // R9

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_clk_a,
    input  logic             ext_clk_b,
    input  logic             cap_pin_a,
    input  logic             cap_pin_b,
    output logic             cmp_out_a,
    output logic             cmp_out_b,
    output logic             irq
);

    localparam int PAD = CNT_W - REG_W;

    ctrl_t             ctrl_q;
    logic [REG_W-1:0]  ioc_q, ien_q, flags_q, seen_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt;
    logic [CNT_W-1:0]  gr_val [N_GR];
    logic [N_GR-1:0]   hit, cap, pin, gr_wr, cap_in;
    logic              tick, adv, clr_hit, wrap;
    logic              ctrl_wr, ioc_wr, ien_wr, stat_wr, cnt_wr, stat_rd;
    logic [REG_W-1:0]  set_vec, clr_vec;

    assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
    assign ioc_wr  = bus_wr && (bus_addr == ADR_IOC);
    assign ien_wr  = bus_wr && (bus_addr == ADR_IEN);
    assign stat_wr = bus_wr && (bus_addr == ADR_STAT);
    assign cnt_wr  = bus_wr && (bus_addr == ADR_CNT);
    assign stat_rd = bus_rd && (bus_addr == ADR_STAT);
    assign gr_wr   = {bus_wr && (bus_addr == ADR_GRB), bus_wr && (bus_addr == ADR_GRA)};
    assign cap_in  = {cap_pin_b, cap_pin_a};

    tmr_tick_gen #(.SYNC_N(SYNC_N)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .clk_sel  (ctrl_q.clk_sel),
        .edge_sel (ctrl_q.edge_sel),
        .ext_a    (ext_clk_a),
        .ext_b    (ext_clk_b),
        .tick     (tick)
    );

    generate
        for (genvar g = 0; g < N_GR; g++) begin : g_gr
            tmr_gr_unit #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_gr (
                .clk     (clk),
                .rst     (rst),
                .ioc     (ioc_q[4*g +: 4]),
                .ioc_new (bus_wdata[4*g +: 4]),
                .ioc_wr  (ioc_wr),
                .gr_wr   (gr_wr[g]),
                .wdata   (bus_wdata),
                .adv     (adv),
                .cnt     (cnt_q),
                .cnt_nxt (cnt_nxt),
                .cap_pin (cap_in[g]),
                .gr      (gr_val[g]),
                .hit     (hit[g]),
                .cap_evt (cap[g]),
                .pin     (pin[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (ctrl_q.clr_sel)
            3'd1:    clr_hit = is_compare(ioc_q[3:0]) && (cnt_q == gr_val[0]);
            3'd2:    clr_hit = is_compare(ioc_q[7:4]) && (cnt_q == gr_val[1]);
            default: clr_hit = 1'b0;
        endcase
    end

    assign cnt_nxt = clr_hit ? '0 : cnt_q + 1'b1;
    assign wrap    = !clr_hit && (cnt_q == '1);
    assign adv     = tick && !cnt_wr;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (cnt_wr) cnt_q <= bus_wdata;
        else if (adv)    cnt_q <= cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ioc_q  <= '0;
            ien_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[REG_W-1:0]);
            if (ioc_wr)  ioc_q  <= bus_wdata[REG_W-1:0];
            if (ien_wr)  ien_q  <= bus_wdata[REG_W-1:0];
        end
    end

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_A]   = hit[0] | cap[0];
        set_vec[FLG_B]   = hit[1] | cap[1];
        set_vec[FLG_OVF] = adv && wrap;
        clr_vec          = stat_wr ? (seen_q & ~bus_wdata[REG_W-1:0] & FLAG_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            seen_q  <= '0;
        end else begin
            flags_q <= ((flags_q & ~clr_vec) | set_vec) & FLAG_MASK;
            if (stat_rd)      seen_q <= flags_q;
            else if (stat_wr) seen_q <= seen_q & ~clr_vec;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = {{PAD{1'b0}}, ctrl_q};
            ADR_IOC:  bus_rdata = {{PAD{1'b0}}, ioc_q};
            ADR_IEN:  bus_rdata = {{PAD{1'b0}}, ien_q};
            ADR_STAT: bus_rdata = {{PAD{1'b0}}, flags_q};
            ADR_CNT:  bus_rdata = cnt_q;
            ADR_GRA:  bus_rdata = gr_val[0];
            ADR_GRB:  bus_rdata = gr_val[1];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq       = |(flags_q & ien_q & FLAG_MASK);
    assign cmp_out_a = pin[0];
    assign cmp_out_b = pin[1];

    AST_FREEZE_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt_q)); // R2
    AST_CLEAR_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
        (adv && ctrl_q.clr_sel == 3'd1 && is_compare(ioc_q[3:0]) && cnt_q == gr_val[0])
        |=> (cnt_q == '0)); // R6
    AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr_hit && cnt_q == '1) |=> flags_q[FLG_OVF]); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(flags_q) & ~flags_q) == '0)); // R11

endmodule

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_a = 1'b0, ext_b = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
    logic        pin_a, pin_b, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst(rst), .run(run),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_a(ext_a), .ext_clk_b(ext_b),
        .cap_pin_a(cap_a), .cap_pin_b(cap_b),
        .cmp_out_a(pin_a), .cmp_out_b(pin_b), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        rd(3'd3, d);
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        peek(3'd0, d); check("R1 ctrl", d, 16'h0);
        peek(3'd1, d); check("R1 ioc", d, 16'h0);
        peek(3'd2, d); check("R1 ien", d, 16'h0);
        peek(3'd3, d); check("R1 stat", d, 16'h0);
        peek(3'd4, d); check("R1 cnt", d, 16'h0);
        peek(3'd5, d); check("R1 gra", d, 16'hFFFF);
        peek(3'd6, d); check("R1 grb", d, 16'hFFFF);
        check("R1 pins/irq", {pin_b, pin_a, irq}, 3'b000);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(3'd0, 16'h00A5); peek(3'd0, d); check("R13 ctrl readback", d, 16'h00A5);
        wr(3'd5, 16'hBEEF); peek(3'd5, d); check("R13 gra readback", d, 16'hBEEF);
        wr(3'd4, 16'h1357); peek(3'd4, d); check("R13 cnt readback", d, 16'h1357);
        peek(3'd7, d); check("R13 unused address", d, 16'h0);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_interval(input logic [7:0] ctl, input int exp, input string tag);
        int chg[3];
        int k = 0;
        logic [15:0] prev, cur;
        wr(3'd0, {8'h00, ctl});
        wr(3'd4, 16'h0000);
        @(negedge clk);
        bus_addr = 3'd4; prev = 16'h0; run = 1'b1;
        for (int i = 0; i < 5000 && k < 3; i++) begin
            @(negedge clk);
            cur = bus_rdata;
            if (cur != prev) begin chg[k] = i; k++; end
            prev = cur;
        end
        run = 1'b0;
        check(tag, (k == 3) ? chg[2] - chg[1] : -1, exp);
    endtask

    task automatic t_freeze();
        logic [15:0] v1, v2;
        wr(3'd0, 16'h0000); wr(3'd4, 16'h0100);
        run = 1'b1; repeat (5) @(negedge clk); run = 1'b0;
        peek(3'd4, v1);
        repeat (10) @(negedge clk);
        peek(3'd4, v2);
        check("R2 counted while run", (v1 != 16'h0100), 1);
        check("R2 held while stopped", v2, v1);
    endtask

    task automatic t_clear_match();
        logic [15:0] cur, d;
        int first = -1, second = -1;
        wr(3'd1, 16'h0003);
        check("R8 code 3 starts low", pin_a, 1'b0);
        wr(3'd5, 16'h0004); wr(3'd0, 16'h0020); wr(3'd4, 16'h0000);
        clear_flags();
        @(negedge clk);
        bus_addr = 3'd4; run = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cur = bus_rdata;
            if (cur == 16'h4 && first < 0) begin
                first = i;
                check("R8 toggle on first match", pin_a, 1'b1);
            end else if (first >= 0 && i == first + 1) begin
                check("R6 counter cleared after match", cur, 16'h0);
            end else if (cur == 16'h4 && first >= 0 && second < 0) begin
                second = i;
                check("R8 toggle on second match", pin_a, 1'b0);
            end
        end
        run = 1'b0;
        check("R6 period is GR+1 ticks", second - first, 5);
        peek(3'd3, d);
        check("R7 match flag A", d[0], 1'b1);
    endtask

    task automatic t_flag_clear();
        logic [15:0] d;
        wr(3'd3, 16'h0000); peek(3'd3, d);
        check("R11 zero write without read ignored", d[0], 1'b1);
        rd(3'd3, d);
        wr(3'd3, 16'h00FF); peek(3'd3, d);
        check("R11 writing one keeps flag", d[0], 1'b1);
        wr(3'd3, 16'h0000); peek(3'd3, d);
        check("R11 read then zero clears", d[0], 1'b0);
    endtask

    task automatic t_overflow();
        logic [15:0] d;
        wr(3'd1, 16'h0000); wr(3'd0, 16'h0000); wr(3'd2, 16'h0000);
        wr(3'd4, 16'hFFFD);
        run = 1'b1; repeat (6) @(negedge clk); run = 1'b0;
        peek(3'd3, d);
        check("R10 overflow flag", d[4], 1'b1);
        check("R12 masked irq low", irq, 1'b0);
        wr(3'd2, 16'h0010);
        check("R12 enabled overflow raises irq", irq, 1'b1);
        wr(3'd2, 16'h0003);
        check("R12 other enables keep irq low", irq, 1'b0);
        clear_flags();
        wr(3'd2, 16'h0000);
    endtask

    task automatic t_pins();
        wr(3'd1, 16'h0006); check("R8 code 6 starts high", pin_a, 1'b1);
        wr(3'd1, 16'h0001); check("R8 code 1 starts low", pin_a, 1'b0);
        wr(3'd1, 16'h0051); check("R8 code 5 on B starts high", pin_b, 1'b1);
        wr(3'd1, 16'h0002); wr(3'd5, 16'h0003); wr(3'd0, 16'h0020); wr(3'd4, 16'h0000);
        run = 1'b1; repeat (10) @(negedge clk); run = 1'b0;
        check("R8 set on match", pin_a, 1'b1);
        wr(3'd1, 16'h0000);
        check("R8 code 0 keeps pins", {pin_b, pin_a}, 2'b11);
        clear_flags();
    endtask

    task automatic ext_pulse(input int which);
        @(negedge clk);
        if (which == 0) ext_a = 1'b1; else ext_b = 1'b1;
        repeat (4) @(negedge clk);
        if (which == 0) ext_a = 1'b0; else ext_b = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_ext();
        logic [15:0] d;
        wr(3'd0, 16'h0006); wr(3'd4, 16'h0000); run = 1'b1;
        repeat (3) ext_pulse(0);
        repeat (2) ext_pulse(1);
        repeat (4) @(negedge clk); run = 1'b0;
        peek(3'd4, d); check("R5 ext A rising counts, B ignored", d, 16'h3);
        wr(3'd0, 16'h0016); wr(3'd4, 16'h0000); run = 1'b1;
        repeat (3) ext_pulse(0);
        repeat (4) @(negedge clk); run = 1'b0;
        peek(3'd4, d); check("R4 ext A both edges", d, 16'h6);
        wr(3'd0, 16'h0007); wr(3'd4, 16'h0000); run = 1'b1;
        repeat (2) ext_pulse(0);
        repeat (2) ext_pulse(1);
        repeat (4) @(negedge clk); run = 1'b0;
        peek(3'd4, d); check("R5 ext B rising counts", d, 16'h2);
    endtask

    task automatic t_capture();
        logic [15:0] d;
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0080); wr(3'd4, 16'h1234);
        @(negedge clk); cap_b = 1'b1; repeat (5) @(negedge clk);
        peek(3'd6, d); check("R9 rising capture", d, 16'h1234);
        peek(3'd3, d); check("R9 capture flag B", d[1], 1'b1);
        wr(3'd1, 16'h0090); wr(3'd4, 16'h5555);
        @(negedge clk); cap_b = 1'b0; repeat (5) @(negedge clk);
        peek(3'd6, d); check("R9 falling capture", d, 16'h5555);
        wr(3'd4, 16'h6666);
        @(negedge clk); cap_b = 1'b1; repeat (5) @(negedge clk);
        peek(3'd6, d); check("R9 rising ignored in falling mode", d, 16'h5555);
        wr(3'd1, 16'h00A0); wr(3'd4, 16'h7777);
        @(negedge clk); cap_b = 1'b0; repeat (5) @(negedge clk);
        peek(3'd6, d); check("R9 either-edge capture", d, 16'h7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_interval(8'h00, 1,    "R3 divide by 1");
        t_interval(8'h01, 4,    "R3 divide by 4");
        t_interval(8'h02, 16,   "R3 divide by 16");
        t_interval(8'h03, 64,   "R3 divide by 64");
        t_interval(8'h04, 256,  "R3 divide by 256");
        t_interval(8'h05, 1024, "R3 divide by 1024");
        t_interval(8'h0A, 16,   "R4 falling edge divide by 16");
        t_interval(8'h12, 8,    "R4 both edges divide by 16");
        t_interval(8'h10, 1,    "R3 divide by 1 ignores edge");
        t_freeze();
        t_clear_match();
        t_flag_clear();
        t_overflow();
        t_pins();
        t_ext();
        t_capture();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule